// File: doc/BRIEF.md
# Three-Bus Register File

This block is the general-purpose register bank of a microprogrammed datapath. It has two read buses, A and B, and one write bus, C. On every cycle, encoded select fields from the microinstruction pick which register drives bus A and which drives bus B. The two choices are independent of each other. A third encoded field names the register that takes the value on bus C. That load happens only while the global C-enable is high.

A control module decodes the three select fields into one-hot strobes. As a result, each read bus has at most one source and at most one register loads per edge. The datapath module holds the registers, performs the clocked loads and builds each read bus with an AND-OR mux from its one-hot strobe. The register width and the register count are parameters. A select code at or above the register count addresses nothing.

Top module: `tribus_regfile`

## Requirements
- R1: A synchronous reset, active high on `rst`, clears every register to zero. Reset takes priority over a write requested on the same edge.
- R2: `busA` equals, combinationally, the current contents of the register whose index is `selA`.
- R3: `busB` equals, combinationally, the current contents of the register whose index is `selB`, independently of `selA`.
- R4: When `selA` equals `selB`, both buses carry the same register value.
- R5: When `encC` is 1 at a rising clock edge, the register indexed by `selC` loads `busC`. The new value appears on A and B from the following cycle.
- R6: When `encC` is 0 at a rising clock edge, no register changes.
- R7: A write changes only the register indexed by `selC`. Every other register keeps its value.
- R8: A read select of `NUM_REGS` or more (12 to 15 by default) drives zero onto its bus.
- R9: A write with `selC` of `NUM_REGS` or more changes no register.
- R10: At most one register is enabled onto each read bus, and at most one register loads per edge.
- R11: During a cycle that writes a register, a bus reading that register still shows its old value until the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| selA | input | 4 | Register index driven onto bus A |
| selB | input | 4 | Register index driven onto bus B |
| selC | input | 4 | Register index loaded from bus C |
| encC | input | 1 | Global enable for the bus C load |
| busC | input | REG_W | Write data |
| busA | output | REG_W | Read bus A |
| busB | output | REG_W | Read bus B |

## Verification
The read buses are combinational from the stored registers, so the effect of a select change is due in the same cycle. The effect of a write is due one cycle later, after a single register stage. The bench changes inputs just after a falling edge and compares the buses one nanosecond later, before the next rising edge. The expected values in each row therefore describe the state before that row's own write, which is what makes the old-value case (R11) observable. The clocked assertions look exactly one edge back, which matches the single register stage between `busC` and the buses.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int SEL_W    = 4;
  localparam int MAX_REGS = 1 << SEL_W;

  typedef struct packed {
    logic [MAX_REGS-1:0] aHot;
    logic [MAX_REGS-1:0] bHot;
    logic [MAX_REGS-1:0] wrHot;
  } strobe_t;
endpackage

// File: rtl/rf_ctrl.sv
module rf_ctrl #(
  parameter int NUM_REGS = 12
) (
  input  logic [rf_pkg::SEL_W-1:0] selA,
  input  logic [rf_pkg::SEL_W-1:0] selB,
  input  logic [rf_pkg::SEL_W-1:0] selC,
  input  logic                     encC,
  output rf_pkg::strobe_t          strb
);
  localparam int SW = rf_pkg::SEL_W;

  // One decoder slot per encodable code; codes past the bank decode to nothing.
  for (genvar i = 0; i < rf_pkg::MAX_REGS; i++) begin : g_dec
    if (i < NUM_REGS) begin : g_live
      assign strb.aHot[i]  = (selA == SW'(i));
      assign strb.bHot[i]  = (selB == SW'(i));
      assign strb.wrHot[i] = encC && (selC == SW'(i));
    end else begin : g_dead
      assign strb.aHot[i]  = 1'b0;
      assign strb.bHot[i]  = 1'b0;
      assign strb.wrHot[i] = 1'b0;
    end
  end
endmodule

// File: rtl/rf_data.sv
module rf_data #(
  parameter int REG_W    = 16,
  parameter int NUM_REGS = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_REGS-1:0] aHot,
  input  logic [NUM_REGS-1:0] bHot,
  input  logic [NUM_REGS-1:0] wrHot,
  input  logic [REG_W-1:0]    busC,
  output logic [REG_W-1:0]    busA,
  output logic [REG_W-1:0]    busB
);
  logic [REG_W-1:0] regs [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)           regs[i] <= '0;
      else if (wrHot[i]) regs[i] <= busC;
    end
  end

  // AND-OR read muxes: a one-hot strobe leaves exactly one term live.
  always_comb begin
    busA = '0;
    busB = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      busA |= regs[i] & {REG_W{aHot[i]}};
      busB |= regs[i] & {REG_W{bHot[i]}};
    end
  end
endmodule

// File: rtl/tribus_regfile.sv
module tribus_regfile #(
  parameter int REG_W    = 16,
  parameter int NUM_REGS = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [rf_pkg::SEL_W-1:0] selA,
  input  logic [rf_pkg::SEL_W-1:0] selB,
  input  logic [rf_pkg::SEL_W-1:0] selC,
  input  logic                     encC,
  input  logic [REG_W-1:0]         busC,
  output logic [REG_W-1:0]         busA,
  output logic [REG_W-1:0]         busB
);
  rf_pkg::strobe_t strb;

  rf_ctrl #(.NUM_REGS(NUM_REGS)) u_ctrl (
    .selA(selA), .selB(selB), .selC(selC), .encC(encC), .strb(strb)
  );

  rf_data #(.REG_W(REG_W), .NUM_REGS(NUM_REGS)) u_data (
    .clk(clk), .rst(rst),
    .aHot(strb.aHot[NUM_REGS-1:0]),
    .bHot(strb.bHot[NUM_REGS-1:0]),
    .wrHot(strb.wrHot[NUM_REGS-1:0]),
    .busC(busC), .busA(busA), .busB(busB)
  );
endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
  parameter int REG_W    = 16,
  parameter int NUM_REGS = 12
) (
  input logic                     clk,
  input logic                     rst,
  input logic [rf_pkg::SEL_W-1:0] selA,
  input logic [rf_pkg::SEL_W-1:0] selB,
  input logic [rf_pkg::SEL_W-1:0] selC,
  input logic                     encC,
  input logic [REG_W-1:0]         busC,
  input logic [REG_W-1:0]         busA,
  input logic [REG_W-1:0]         busB,
  input rf_pkg::strobe_t          strb
);
  AST_ONE_DRIVER_A: assert property (@(posedge clk) disable iff (rst) $onehot0(strb.aHot)); // R10
  AST_ONE_DRIVER_B: assert property (@(posedge clk) disable iff (rst) $onehot0(strb.bHot)); // R10
  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (rst) $onehot0(strb.wrHot)); // R10
  AST_SAME_SEL: assert property (@(posedge clk) disable iff (rst) (selA == selB) |-> (busA == busB)); // R4
  AST_OOR_READ: assert property (@(posedge clk) disable iff (rst) (int'(selA) >= NUM_REGS) |-> (busA == '0)); // R8
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (encC && int'(selC) < NUM_REGS) |=> ((selA != $past(selC)) || (busA == $past(busC)))); // R5
  AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (rst)
    (!encC) |=> ((selB != $past(selB)) || $stable(busB))); // R6
endmodule

bind tribus_regfile rf_checker #(.REG_W(REG_W), .NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst(rst), .selA(selA), .selB(selB), .selC(selC), .encC(encC),
  .busC(busC), .busA(busA), .busB(busB), .strb(strb)
);

// File: tb/sim_tribus_regfile.sv
module sim_tribus_regfile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  selA = '0, selB = '0, selC = '0;
  logic        encC = 1'b0;
  logic [15:0] busC = '0;
  logic [15:0] busA, busB;
  int nChk = 0, nBad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  tribus_regfile #(.REG_W(16), .NUM_REGS(12)) u0 (
    .clk(clk), .rst(rst), .selA(selA), .selB(selB), .selC(selC),
    .encC(encC), .busC(busC), .busA(busA), .busB(busB)
  );

  typedef struct packed {
    logic        en;
    logic [3:0]  sc;
    logic [15:0] dc;
    logic [3:0]  sa;
    logic [3:0]  sb;
    logic [15:0] ea;
    logic [15:0] eb;
  } vec_t;

  // Expected buses show the state before the row's own write lands.
  localparam vec_t VEC [10] = '{
    '{1'b1, 4'd1,  16'h1111, 4'd1,  4'd2,  16'h0000, 16'h0000}, // R2 R3
    '{1'b1, 4'd2,  16'h2222, 4'd1,  4'd2,  16'h1111, 16'h0000}, // R5 R7
    '{1'b1, 4'd11, 16'hBBBB, 4'd2,  4'd1,  16'h2222, 16'h1111}, // R5 R7
    '{1'b0, 4'd3,  16'hDEAD, 4'd11, 4'd3,  16'hBBBB, 16'h0000}, // R5
    '{1'b1, 4'd12, 16'hF00D, 4'd3,  4'd12, 16'h0000, 16'h0000}, // R6 R8
    '{1'b1, 4'd0,  16'h0A0A, 4'd1,  4'd1,  16'h1111, 16'h1111}, // R4
    '{1'b1, 4'd1,  16'h5555, 4'd1,  4'd0,  16'h1111, 16'h0A0A}, // R11
    '{1'b0, 4'd0,  16'h0000, 4'd1,  4'd15, 16'h5555, 16'h0000}, // R8 R11
    '{1'b1, 4'd3,  16'hFFFF, 4'd12, 4'd11, 16'h0000, 16'hBBBB}, // R8 R10
    '{1'b0, 4'd5,  16'h1234, 4'd3,  4'd2,  16'hFFFF, 16'h2222}  // R6 R10
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string rowTag(input int r);
    case (r)
      0: return "R2 R3";
      1, 2: return "R5 R7";
      3: return "R5";
      4: return "R6 R8";
      5: return "R4";
      6: return "R11";
      7: return "R8 R11";
      8: return "R8 R10";
      default: return "R6 R10";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    logic [15:0] model [12];
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: every register reads zero after reset
    for (int i = 0; i < 12; i++) begin
      selA = 4'(i); selB = 4'(11 - i);
      #1;
      check("R1 busA", busA, 16'h0);
      check("R1 busB", busB, 16'h0);
    end

    for (int r = 0; r < 10; r++) begin
      @(negedge clk);
      encC = VEC[r].en; selC = VEC[r].sc; busC = VEC[r].dc;
      selA = VEC[r].sa; selB = VEC[r].sb;
      #1;
      check({rowTag(r), " busA"}, busA, VEC[r].ea);
      check({rowTag(r), " busB"}, busB, VEC[r].eb);
    end

    // R7 R9 R6: full scan against the expected bank
    @(negedge clk);
    encC = 1'b0;
    foreach (model[i]) model[i] = 16'h0;
    model[0] = 16'h0A0A; model[1] = 16'h5555; model[2] = 16'h2222;
    model[3] = 16'hFFFF; model[11] = 16'hBBBB;
    for (int i = 0; i < 12; i++) begin
      selA = 4'(i); selB = 4'(i);
      #1;
      check("R7 R9 scan busA", busA, model[i]);
      check("R6 R9 scan busB", busB, model[i]);
    end

    // R1: reset wins over a same-edge write
    @(negedge clk);
    rst = 1'b1; encC = 1'b1; selC = 4'd4; busC = 16'hCAFE;
    @(negedge clk);
    rst = 1'b0; encC = 1'b0;
    selA = 4'd4; selB = 4'd1;
    #1;
    check("R1 reset beats write", busA, 16'h0);
    check("R1 cleared", busB, 16'h0);

    // R5: write then read next cycle on B
    @(negedge clk);
    encC = 1'b1; selC = 4'd7; busC = 16'h7777; selB = 4'd7;
    #1;
    check("R11 before edge", busB, 16'h0);
    @(negedge clk);
    encC = 1'b0;
    #1;
    check("R5 after edge", busB, 16'h7777);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule